// File: doc/BRIEF.md
# Codeblock Framer with Sync Marker and Randomiser

This block sits on the serial output side of a turbo encoder. For every codeblock it first sends an attached sync marker, whose length and pattern depend on the selected code rate, and then passes the codeblock symbols one by one. Before each symbol leaves, it is XORed with a pseudo-random bit sequence. The sequence generator restarts from the all-ones state at every codeblock. A per-block bypass setting lets symbols through unchanged, with no marker and no randomising.

The symbol source offers one symbol per handshake on a valid/ready pair. A start flag marks the first symbol of each codeblock. When the framer sees a valid symbol with the start flag set, it samples the rate, randomiser-enable and bypass inputs. It then holds that first symbol (ready low) while the marker is sent. After the marker it accepts the codeblock symbols. A later symbol that carries the start flag closes the current codeblock and begins the next one. The framer's output is a single registered serial bit with a valid strobe.

Top module: `cbf_framer`

## Requirements
- R1: After reset, and until a start-flagged symbol is presented, `out_valid` is 0 and `sym_ready` is 0. This holds even while a symbol without the start flag is offered.
- R2: The sync marker length is 64, 96, 128 or 192 bits for `rate_sel` = 0 (rate 1/2), 1 (1/3), 2 (1/4) and 3 (1/6).
- R3: The marker bits are sent most significant first and are never randomised. The patterns are:
  - rate 1/2: 034776C7272895B0
  - rate 1/3: 25D5C0CE8990F6C9461BF79C
  - rate 1/4: the rate 1/2 pattern followed by its bitwise complement
  - rate 1/6: the rate 1/3 pattern followed by its bitwise complement
- R4: The start-flagged symbol is accepted exactly L+2 clock edges after it is first presented, where L is the marker length. In bypass it is accepted after 2 edges. `sym_ready` stays 0 while the marker is being sent.
- R5: With randomising enabled, accepted symbol k of a codeblock leaves as symbol XOR p(k). The bits p(0..7) are all 1. For n ≥ 0, p(n+8) = p(n+7) ^ p(n+5) ^ p(n+3) ^ p(n), which is the sequence of x^8+x^7+x^5+x^3+1. The first 16 bits are FF48 hex.
- R6: The randomiser restarts at p(0) at every codeblock, including a codeblock that follows a bypassed one.
- R7: The randomiser advances only on accepted codeblock symbols. Idle cycles and marker bits do not advance it.
- R8: With `rand_en` = 0 sampled at the codeblock start, symbols leave unchanged after the marker.
- R9: With `bypass` = 1 sampled at the codeblock start, no marker is sent and symbols leave unchanged, whatever `rand_en` is.
- R10: `rate_sel`, `rand_en` and `bypass` are sampled only when a codeblock starts. Changing them during a codeblock has no effect on that codeblock.
- R11: Marker bit i is visible 2+i cycles after the start symbol is first presented. Each accepted symbol appears on `out_bit` with `out_valid` = 1 in the cycle after it is accepted. At all other times `out_valid` is 0.
- R12: A start-flagged symbol that arrives after a codeblock is under way ends that codeblock and starts a new one, with the same timing as a first codeblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_in | input | 1 | Codeblock symbol |
| sym_valid | input | 1 | Symbol offered |
| sym_start | input | 1 | Offered symbol is the first of a codeblock |
| sym_ready | output | 1 | Symbol taken at this edge when valid |
| rate_sel | input | 2 | Code rate: 0=1/2, 1=1/3, 2=1/4, 3=1/6 |
| rand_en | input | 1 | Enable randomising of codeblock symbols |
| bypass | input | 1 | Pass symbols without marker or randomising |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | Output bit is valid |

## Verification
The output register makes marker bit i due 2+i cycles after the start symbol is first presented. Each accepted symbol is due exactly one cycle after the edge that takes it, and the start symbol itself is taken L+2 edges after presentation. The bench records the cycle number of every presentation and acceptance edge. It logs every valid output bit with the cycle it appeared in, and compares both the bit and its cycle against the expected stream built from these rules. Inputs are driven and outputs sampled on the falling edge, so each due cycle maps onto exactly one sample.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef enum logic [1:0] {
    RATE_HALF    = 2'd0,
    RATE_THIRD   = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_SIXTH   = 2'd3
  } rate_e;

  localparam int SYNC_BASE = 32;
  localparam int MARK_MAX  = 6 * SYNC_BASE;
  localparam int MCNT_W    = $clog2(MARK_MAX);
  localparam int PRBS_W    = 8;
  localparam logic [PRBS_W-1:0] PRBS_TAPS = 8'hA9;  // bits 7,5,3,0
  localparam logic [PRBS_W-1:0] PRBS_SEED = '1;

  localparam logic [63:0] SYNC_HALF  = 64'h034776C7_272895B0;
  localparam logic [95:0] SYNC_THIRD = 96'h25D5C0CE_8990F6C9_461BF79C;

  function automatic int unsigned rate_mult(rate_e r);
    case (r)
      RATE_HALF:    return 2;
      RATE_THIRD:   return 3;
      RATE_QUARTER: return 4;
      default:      return 6;
    endcase
  endfunction

  function automatic logic [MCNT_W-1:0] mark_last_idx(rate_e r);
    return MCNT_W'(SYNC_BASE * rate_mult(r) - 1);
  endfunction

  // Longer markers are the shorter pattern followed by its complement.
  function automatic logic mark_bit(rate_e r, logic [MCNT_W-1:0] idx);
    case (r)
      RATE_HALF:  return SYNC_HALF[6'(MCNT_W'(63) - idx)];
      RATE_THIRD: return SYNC_THIRD[7'(MCNT_W'(95) - idx)];
      RATE_QUARTER:
        if (idx < MCNT_W'(64)) return SYNC_HALF[6'(MCNT_W'(63) - idx)];
        else                   return ~SYNC_HALF[6'(MCNT_W'(127) - idx)];
      default:
        if (idx < MCNT_W'(96)) return SYNC_THIRD[7'(MCNT_W'(95) - idx)];
        else                   return ~SYNC_THIRD[7'(MCNT_W'(191) - idx)];
    endcase
  endfunction
endpackage

// File: rtl/cbf_prbs.sv
module cbf_prbs #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hA9,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic         step,
  output logic         pbit,
  output logic [W-1:0] state
);
  logic [W-1:0] win_q;

  // win_q[0] is the current sequence bit, win_q[W-1] the newest
  function automatic logic [W-1:0] advance(logic [W-1:0] w);
    return {^(w & TAPS), w[W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     win_q <= SEED;
    else if (seed)  win_q <= SEED;
    else if (step)  win_q <= advance(win_q);
  end

  assign pbit  = win_q[0];
  assign state = win_q;
endmodule

// File: rtl/cbf_marker.sv
module cbf_marker
  import cbf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  rate_e rate,
  output logic  busy,
  output logic  mbit,
  output logic  last
);
  logic [MCNT_W-1:0] cnt_q;
  logic              busy_q;

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == mark_last_idx(rate));
  assign mbit = mark_bit(rate, cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbf_ctrl.sv
module cbf_ctrl
  import cbf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_valid,
  input  logic  sym_start,
  input  rate_e rate_in,
  input  logic  rand_in,
  input  logic  bypass_in,
  input  logic  mark_last,
  output logic  sym_ready,
  output logic  accept,
  output logic  start_evt,
  output logic  mark_load,
  output rate_e cfg_rate,
  output logic  cfg_rand,
  output logic  cfg_bypass
);
  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_DATA} st_e;

  st_e  st_q;
  logic head_q;   // next accepted symbol is the codeblock's first

  logic may_open;
  assign may_open  = (st_q == ST_IDLE) || ((st_q == ST_DATA) && !head_q);
  assign start_evt = sym_valid && sym_start && may_open;
  assign sym_ready = (st_q == ST_DATA) && (head_q || !sym_start);
  assign accept    = sym_valid && sym_ready;
  assign mark_load = start_evt && !bypass_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      head_q     <= 1'b0;
      cfg_rate   <= RATE_HALF;
      cfg_rand   <= 1'b0;
      cfg_bypass <= 1'b0;
    end else if (start_evt) begin
      cfg_rate   <= rate_in;
      cfg_rand   <= rand_in;
      cfg_bypass <= bypass_in;
      head_q     <= 1'b1;
      st_q       <= bypass_in ? ST_DATA : ST_MARK;
    end else begin
      if ((st_q == ST_MARK) && mark_last) st_q <= ST_DATA;
      if (accept) head_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cbf_framer.sv
module cbf_framer
  import cbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_in,
  input  logic       sym_valid,
  input  logic       sym_start,
  output logic       sym_ready,
  input  logic [1:0] rate_sel,
  input  logic       rand_en,
  input  logic       bypass,
  output logic       out_bit,
  output logic       out_valid
);
  // named internal events, also observed by the bound checker
  logic              accept;
  logic              start_evt;
  logic              mark_load;
  logic              mark_busy;
  logic              mark_bit_w;
  logic              mark_last;
  rate_e             cfg_rate;
  logic              cfg_rand;
  logic              cfg_bypass;
  logic              prbs_bit;
  logic [PRBS_W-1:0] prbs_state;
  logic              scramble;

  cbf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .sym_start  (sym_start),
    .rate_in    (rate_e'(rate_sel)),
    .rand_in    (rand_en),
    .bypass_in  (bypass),
    .mark_last  (mark_last),
    .sym_ready  (sym_ready),
    .accept     (accept),
    .start_evt  (start_evt),
    .mark_load  (mark_load),
    .cfg_rate   (cfg_rate),
    .cfg_rand   (cfg_rand),
    .cfg_bypass (cfg_bypass)
  );

  cbf_marker u_marker (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mark_load),
    .rate  (cfg_rate),
    .busy  (mark_busy),
    .mbit  (mark_bit_w),
    .last  (mark_last)
  );

  cbf_prbs #(.W(PRBS_W), .TAPS(PRBS_TAPS), .SEED(PRBS_SEED)) u_prbs (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (start_evt),
    .step  (accept),
    .pbit  (prbs_bit),
    .state (prbs_state)
  );

  assign scramble = cfg_rand && !cfg_bypass && prbs_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= mark_busy || accept;
      out_bit   <= mark_busy ? mark_bit_w : (sym_in ^ scramble);
    end
  end
endmodule

// File: rtl/cbf_framer_chk.sv
module cbf_framer_chk
  import cbf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sym_in,
  input logic              sym_ready,
  input logic              out_bit,
  input logic              out_valid,
  input logic              accept,
  input logic              start_evt,
  input logic              mark_busy,
  input logic              cfg_rand,
  input logic              cfg_bypass,
  input logic [PRBS_W-1:0] prbs_state
);
  a_r4_marker_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
    mark_busy |-> !sym_ready);

  a_r11_symbol_due: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r11_marker_due: assert property (@(posedge clk) disable iff (!rst_n)
    mark_busy |=> out_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept || mark_busy) |=> !out_valid);

  a_r9_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_bypass) |=> (out_bit == $past(sym_in)));

  a_r8_plain_data: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_rand) |=> (out_bit == $past(sym_in)));

  a_r6_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (prbs_state == PRBS_SEED));

  a_r7_prbs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start_evt) |=> $stable(prbs_state));
endmodule

bind cbf_framer cbf_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sym_in     (sym_in),
  .sym_ready  (sym_ready),
  .out_bit    (out_bit),
  .out_valid  (out_valid),
  .accept     (accept),
  .start_evt  (start_evt),
  .mark_busy  (mark_busy),
  .cfg_rand   (cfg_rand),
  .cfg_bypass (cfg_bypass),
  .prbs_state (prbs_state)
);

// File: tb/test_cbf_framer.sv
module test_cbf_framer;
  logic clk = 1'b0;
  logic rst_n, sym_in, sym_valid, sym_start, sym_ready;
  logic [1:0] rate_sel;
  logic rand_en, bypass, out_bit, out_valid;

  always #4 clk = ~clk;  // 125 MHz

  cbf_framer i_cbf_framer (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .sym_valid(sym_valid),
    .sym_start(sym_start), .sym_ready(sym_ready), .rate_sel(rate_sel),
    .rand_en(rand_en), .bypass(bypass), .out_bit(out_bit), .out_valid(out_valid)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  bit pseq[0:255];
  bit eb[$]; int ec[$]; string er[$];
  bit gb[$]; int gc[$];

  localparam logic [63:0]  M2 = 64'h034776C7272895B0;
  localparam logic [95:0]  M3 = 96'h25D5C0CE8990F6C9461BF79C;
  localparam logic [127:0] M4 = 128'h034776C7272895B0FCB88938D8D76A4F;
  localparam logic [191:0] M6 = 192'h25D5C0CE8990F6C9461BF79CDA2A3F31766F0936B9E40863;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && out_valid) begin gb.push_back(out_bit); gc.push_back(cyc); end

  function automatic int mlen(int r);
    case (r) 0: return 64; 1: return 96; 2: return 128; default: return 192; endcase
  endfunction

  function automatic bit mk(int r, int i);
    case (r)
      0: return M2[63-i];
      1: return M3[95-i];
      2: return M4[127-i];
      default: return M6[191-i];
    endcase
  endfunction

  task automatic check(string req, bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic send_sym(bit b, bit st, output int pres, output int e);
    bit r;
    @(negedge clk);
    sym_in = b; sym_start = st; sym_valid = 1'b1; pres = cyc; e = 0;
    forever begin
      #1 r = sym_ready;
      @(posedge clk); e++;
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic gap(int n);
    repeat (n) begin @(negedge clk); sym_valid = 1'b0; end
  endtask

  task automatic run_block(int r, bit rnd, bit byp, int n, int gap_pct, bit zeros);
    int pres, e, L;
    bit b, x;
    string dreq;
    L = mlen(r);
    dreq = byp ? "R9 R10" : (rnd ? "R5 R6 R7 R10" : "R8 R10");
    @(negedge clk);
    sym_valid = 1'b0; rate_sel = 2'(r); rand_en = rnd; bypass = byp;
    for (int k = 0; k < n; k++) begin
      if (k > 0 && $urandom_range(99) < gap_pct) gap($urandom_range(3, 1));
      b = zeros ? 1'b0 : 1'($urandom_range(1));
      send_sym(b, k == 0, pres, e);
      if (k == 0) begin
        // R2 R4 R12: start symbol held for the whole marker
        check("R2 R4 R12", e == (byp ? 2 : L + 2), "start accept edges", e, byp ? 2 : L + 2);
        if (!byp)
          for (int i = 0; i < L; i++) begin
            eb.push_back(mk(r, i)); ec.push_back(pres + 2 + i); er.push_back("R3");
          end
        @(negedge clk);
        sym_valid = 1'b0;
        rate_sel = 2'($urandom_range(3)); rand_en = 1'($urandom_range(1));
        bypass = 1'($urandom_range(1));  // R10: ignored mid-block
      end
      x = b ^ (rnd && !byp ? pseq[k] : 1'b0);
      eb.push_back(x); ec.push_back(pres + e); er.push_back(dreq);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int nb, r16;
    void'($urandom(32'd4021));
    for (int i = 0; i < 8; i++) pseq[i] = 1'b1;
    for (int i = 0; i < 248; i++) pseq[i+8] = pseq[i+7] ^ pseq[i+5] ^ pseq[i+3] ^ pseq[i];
    rst_n = 1'b0; sym_in = 0; sym_valid = 0; sym_start = 0;
    rate_sel = 0; rand_en = 0; bypass = 0;
    repeat (3) @(negedge clk);
    check("R1", out_valid == 1'b0, "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sym_valid = 1'b1; sym_start = 1'b0;
    repeat (4) begin
      @(negedge clk); #1;
      check("R1", sym_ready == 1'b0, "ready before start", sym_ready, 0);
      check("R1", out_valid == 1'b0, "out_valid before start", out_valid, 0);
    end
    run_block(0, 1, 0, 40, 0, 1);    // R5: zero data shows the sequence
    run_block(1, 0, 0, 20, 0, 0);    // R8
    run_block(2, 1, 0, 30, 50, 0);   // R7: gaps
    run_block(3, 1, 0, 25, 20, 0);   // R2 R3 longest marker
    run_block(0, 1, 1, 15, 20, 0);   // R9
    run_block(1, 1, 0, 12, 0, 0);    // R6 after bypass
    for (int j = 0; j < 6; j++)
      run_block($urandom_range(3), 1'($urandom_range(1)), $urandom_range(3) == 0,
                $urandom_range(40, 5), 30, 0);
    gap(6);
    check("R11", gb.size() == eb.size(), "output bit count", gb.size(), eb.size());
    nb = (gb.size() < eb.size()) ? gb.size() : eb.size();
    for (int i = 0; i < nb; i++) begin
      check(er[i], gb[i] == eb[i], $sformatf("bit %0d", i), gb[i], eb[i]);
      check("R11", gc[i] == ec[i], $sformatf("cycle of bit %0d", i), gc[i], ec[i]);
    end
    r16 = 0;
    for (int i = 0; i < 16; i++) r16 = (r16 << 1) | ((64 + i < gb.size()) ? int'(gb[64+i]) : 0);
    check("R5", r16 == 16'hFF48, "first 16 randomiser bits", r16, 16'hFF48);
    done = 1;
    summary();
    $finish;
  end
endmodule